// File: doc/BRIEF.md
# Modem Status Tracker

This block keeps the 8-bit modem status byte of a serial port controller. Four status lines (clear-to-send, data-set-ready, ring indicator, data carrier detect) are sampled whenever a single-cycle update strobe is pulsed. The upper nibble mirrors the most recently sampled line levels. The lower nibble holds sticky change flags. Each flag is raised when its line is seen to change between two samples.

The byte is always visible on a read port. A single-cycle read strobe marks the cycle in which software consumes it. The change flags are cleared at the end of that cycle. A change sampled in the same cycle as the read is still recorded. When any change flag is set and the interrupt enable input is high, a modem-status interrupt request is driven.

The line inputs are assumed to be already synchronised to the register clock. Interrupt prioritisation and the rest of the register file live elsewhere.

Top module: `modem_status_tracker`

## Requirements
- R1: Bit layout of `stat_q`: bit 7 = carrier level, bit 6 = ring level, bit 5 = data-set-ready level, bit 4 = clear-to-send level, bit 3 = carrier change flag, bit 2 = ring-arrival flag, bit 1 = data-set-ready change flag, bit 0 = clear-to-send change flag.
- R2: Line levels are captured only on a cycle with `upd_stb` high, or on the first clock edge after reset release. On other cycles without a read, `stat_q` holds its value even if the lines move.
- R3: An update sets bit 0 when the sampled clear-to-send level differs from bit 4.
- R4: An update sets bit 1 when the sampled data-set-ready level differs from bit 5.
- R5: An update sets bit 3 when the sampled carrier level differs from bit 7.
- R6: An update sets bit 2 only when the ring line is sampled high while bit 6 is low. Ring going low leaves bit 2 unchanged.
- R7: Change flags are sticky. Later updates only add flags, and an update with no line change clears none.
- R8: During a cycle with `rd_stb` high, `stat_q` shows the value being read. At that clock edge bits 3:0 are cleared and bits 7:4 are kept.
- R9: When `rd_stb` and `upd_stb` coincide, the flags raised by that update survive the clear, and the levels are updated.
- R10: While `rst_n` is low, `stat_q` is 0x00. The first edge after release samples the lines as an update against that zero value.
- R11: `msi_irq` is high exactly when any of bits 3:0 is set and `msi_en` is high, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cts | input | 1 | Clear-to-send level, active high, synchronised |
| line_dsr | input | 1 | Data-set-ready level, active high, synchronised |
| line_ri | input | 1 | Ring indicator level, active high, synchronised |
| line_dcd | input | 1 | Carrier detect level, active high, synchronised |
| upd_stb | input | 1 | Single-cycle sample strobe |
| rd_stb | input | 1 | Single-cycle read strobe; clears change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| stat_q | output | 8 | Modem status byte |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The bench drives the ring line low after it was high and expects bit 2 to stay clear. A design that treated ring like the other lines would raise a spurious flag there. It pulses read and update together on a line change and expects the new flag to remain. A design that gives the clear priority would silently lose that event. It also moves the lines with no strobe, expecting no change, and releases reset with lines already active, expecting them to appear with their flags. A design that samples freely, or that only zeroes the byte at reset, fails these checks.

// File: rtl/modem_status_tracker.sv
module modem_status_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_ri,
  input  logic       line_dcd,
  input  logic       upd_stb,
  input  logic       rd_stb,
  input  logic       msi_en,
  output logic [7:0] stat_q,
  output logic       msi_irq
);

  logic       boot_q;
  logic       sample;
  logic [3:0] lvl_new;
  logic [3:0] lvl_old;
  logic [3:0] chg;
  logic [3:0] flags_kept;
  logic [3:0] flags_next;

  assign sample  = upd_stb | boot_q;
  assign lvl_new = {line_dcd, line_ri, line_dsr, line_cts};
  assign lvl_old = stat_q[7:4];

  // flag order: [3]=carrier, [2]=ring arrival, [1]=dsr, [0]=cts
  assign chg[0] = lvl_new[0] ^ lvl_old[0];
  assign chg[1] = lvl_new[1] ^ lvl_old[1];
  assign chg[2] = lvl_new[2] & ~lvl_old[2];
  assign chg[3] = lvl_new[3] ^ lvl_old[3];

  assign flags_kept = rd_stb ? 4'h0 : stat_q[3:0];
  assign flags_next = flags_kept | (sample ? chg : 4'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      stat_q <= 8'h00;
    end else begin
      boot_q      <= 1'b0;
      stat_q[3:0] <= flags_next;
      if (sample)
        stat_q[7:4] <= lvl_new;
    end
  end

  assign msi_irq = msi_en & (|stat_q[3:0]);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_stb && !rd_stb && !boot_q) |=> $stable(stat_q));

  assert_cts_delta_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && (line_cts != stat_q[4])) |=> stat_q[0]);

  assert_dsr_delta_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && (line_dsr != stat_q[5])) |=> stat_q[1]);

  assert_dcd_delta_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && (line_dcd != stat_q[7])) |=> stat_q[3]);

  assert_ri_fall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && rd_stb && !line_ri) |=> !stat_q[2]);

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !upd_stb && !boot_q) |=> (stat_q[3:0] == 4'h0));

  assert_read_keeps_lvl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !upd_stb && !boot_q) |=> $stable(stat_q[7:4]));

endmodule

// File: tb/modem_status_tracker_tb_top.sv
module modem_status_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_cts = 1'b0, line_dsr = 1'b0, line_ri = 1'b0, line_dcd = 1'b0;
  logic       upd_stb = 1'b0, rd_stb = 1'b0, msi_en = 1'b0;
  logic [7:0] stat_q;
  logic       msi_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_s = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  modem_status_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
    .upd_stb(upd_stb), .rd_stb(rd_stb), .msi_en(msi_en),
    .stat_q(stat_q), .msi_irq(msi_irq)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] predict(input logic [7:0] s, input bit u, input bit r);
    logic [3:0] f;
    logic [3:0] lv;
    f  = r ? 4'h0 : s[3:0];
    lv = s[7:4];
    if (u) begin
      if (line_cts != s[4]) f[0] = 1'b1;
      if (line_dsr != s[5]) f[1] = 1'b1;
      if (line_ri && !s[6]) f[2] = 1'b1;
      if (line_dcd != s[7]) f[3] = 1'b1;
      lv = {line_dcd, line_ri, line_dsr, line_cts};
    end
    return {lv, f};
  endfunction

  task automatic cycle(input bit u, input bit r, input string req);
    logic [7:0] nxt;
    @(negedge clk);
    upd_stb = u;
    rd_stb  = r;
    if (r) chk(stat_q, exp_s, {req, " read value R8"});
    nxt = predict(exp_s, u, r);
    @(negedge clk);
    upd_stb = 1'b0;
    rd_stb  = 1'b0;
    exp_s = nxt;
    chk(stat_q, exp_s, req);
  endtask

  task automatic t_reset_load();
    line_cts = 1; line_dcd = 1;
    repeat (3) @(negedge clk);
    chk(stat_q, 8'h00, "R10 held in reset");
    rst_n = 1'b1;
    @(negedge clk);
    exp_s = 8'h99;
    chk(stat_q, 8'h99, "R10 R1 post-reset load");
  endtask

  task automatic t_read_clear();
    cycle(0, 1, "R8 read clears flags");
    chk(stat_q, 8'h90, "R8 levels kept");
  endtask

  task automatic t_no_strobe();
    line_dsr = 1; line_cts = 0;
    cycle(0, 0, "R2 lines move without strobe");
    chk(stat_q, 8'h90, "R2 unchanged");
    line_dsr = 0; line_cts = 1;
  endtask

  task automatic t_each_line();
    line_cts = 0;
    cycle(1, 0, "R3 cts falls");
    cycle(0, 1, "R8 clear");
    line_dsr = 1;
    cycle(1, 0, "R4 dsr rises");
    cycle(0, 1, "R8 clear");
    line_dcd = 0;
    cycle(1, 0, "R5 dcd falls");
    chk(stat_q, 8'h28, "R5 R1 carrier flag bit3");
    cycle(0, 1, "R8 clear");
  endtask

  task automatic t_ring();
    line_ri = 1;
    cycle(1, 0, "R6 ring rises");
    chk({7'h0, stat_q[2]}, 8'h01, "R6 ring flag set");
    cycle(0, 1, "R8 clear");
    line_ri = 0;
    cycle(1, 0, "R6 ring falls");
    chk({7'h0, stat_q[2]}, 8'h00, "R6 no flag on fall");
  endtask

  task automatic t_sticky();
    line_cts = 1;
    cycle(1, 0, "R7 first change");
    cycle(1, 0, "R7 no change keeps flag");
    line_dsr = 0;
    cycle(1, 0, "R7 accumulate");
    chk(stat_q[3:0], 4'h3, "R7 both flags");
    cycle(0, 1, "R8 clear");
  endtask

  task automatic t_read_and_update();
    line_dcd = 1;
    cycle(1, 1, "R9 simultaneous read and update");
    chk(stat_q, 8'h98, "R9 new flag survives");
    line_ri = 1; line_cts = 0;
    cycle(1, 1, "R9 ring and cts with read");
  endtask

  task automatic t_irq();
    msi_en = 0;
    #1 chk({7'h0, msi_irq}, 8'h00, "R11 disabled");
    msi_en = 1;
    #1 chk({7'h0, msi_irq}, 8'h01, "R11 enabled with flags");
    cycle(0, 1, "R8 clear");
    chk({7'h0, msi_irq}, 8'h00, "R11 no flags");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset_load();
    t_read_clear();
    t_no_strobe();
    t_each_line();
    t_ring();
    t_sticky();
    t_read_and_update();
    t_irq();
    summary();
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

endmodule